// File: doc/BRIEF.md
# Multimode LUT RAM and shift register

This block is a single 64-bit configurable table cell. The 64-bit table can serve three purposes. In the first it is a fixed six-input logic function. In the second it is a 64x1 memory with a synchronous write port. In the third it is a serial delay line of up to 32 stages whose output tap can be chosen. The six address inputs select the output bit in every mode. A single enable input acts as the write strobe in memory mode and as the shift strobe in shift mode.

The table contents come from a configuration value, the `INIT_BITS` parameter. That value is loaded whenever synchronous reset is asserted. Outside reset, the contents change only through memory writes or shifts. Switching mode never erases the contents, so a table filled in one mode can be read in another.

The cell also has a second output that reads the lower half of the table with the low five address bits. This lets the table be used as two five-input functions that share those inputs. In shift mode a cascade output shows the last stage, so cells can be chained into longer delay lines.

Top module: `lut_multimode_cell`

## Requirements
- R1: While `rst` is high at a rising edge, the table is loaded with `INIT_BITS`, so that afterwards `data_out` equals `INIT_BITS[sel_addr]` in logic mode.
- R2: The mode encoding is `op_mode` = 2'b00 for logic, 2'b01 for memory and 2'b10 for shift. In logic mode `data_out` is table bit `sel_addr`, combinationally.
- R3: In logic mode a high `step_en` changes no table bit.
- R4: In memory mode a rising edge with `step_en` high stores `data_in` into bit `sel_addr` and leaves every other bit unchanged.
- R5: In memory mode `data_out` is table bit `sel_addr` in the same cycle the address is applied, with no clock edge needed (read after write sees the new value).
- R6: In shift mode a rising edge with `step_en` high moves bits 0..30 up by one place and puts `data_in` into bit 0. Bits 32..63 are unchanged.
- R7: In shift mode `data_out` is table bit `sel_addr[4:0]` and `sel_addr[5]` is ignored. A bit shifted in therefore appears at tap t after t+1 enabled edges.
- R8: In shift mode with `step_en` low, the table holds its value.
- R9: `chain_out` equals table bit 31 in shift mode and is 0 in the other modes.
- R10: `half_out` always equals table bit {0, `sel_addr[4:0]`}, in every mode.
- R11: Changing `op_mode` does not alter the table contents.
- R12: `op_mode` = 2'b11 behaves exactly like logic mode: reads are the same, and enables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the configuration value |
| op_mode | input | 2 | Mode select: 00 logic, 01 memory, 10 shift, 11 logic |
| sel_addr | input | 6 | Read address; memory write address; shift tap in bits [4:0] |
| data_in | input | 1 | Write data or serial shift input |
| step_en | input | 1 | Write enable in memory mode, shift enable in shift mode |
| data_out | output | 1 | Selected table bit |
| half_out | output | 1 | Lower-half table bit at the low five address bits |
| chain_out | output | 1 | Last shift stage in shift mode, else 0 |

## Verification
On every cycle, the embedded assertions check how the table changes from one edge to the next. A memory write lands at the addressed bit. A shift moves the lower half by one and leaves the upper half alone. The table holds steady when no write or shift is decoded, and in logic and reserved modes. The assertions also check, each cycle, that the half output agrees with the main output in shift mode, and that the cascade output matches tap 31. Only the bench scenarios can show that the reset contents match the configuration value and that every shift tap gives a delay of exactly tap+1 edges. The same holds for contents surviving a round trip through all modes, and for a full memory pattern reading back correctly.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    typedef enum logic [1:0] {
        CELL_LOGIC = 2'b00,
        CELL_RAM   = 2'b01,
        CELL_SHIFT = 2'b10,
        CELL_RSVD  = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic wr_en;
        logic sh_en;
    } store_cmd_t;

    // Reserved encoding folds onto logic mode.
    function automatic cell_mode_e fold_mode(input logic [1:0] raw);
        cell_mode_e m;
        m = cell_mode_e'(raw);
        if (m == CELL_RSVD) m = CELL_LOGIC;
        return m;
    endfunction

endpackage

// File: rtl/lut_cmd_decode.sv
module lut_cmd_decode
    import lut_cell_pkg::*;
(
    input  logic [1:0]  op_mode,
    input  logic        step_en,
    output cell_mode_e  mode,
    output store_cmd_t  cmd
);
    always_comb begin
        mode      = fold_mode(op_mode);
        cmd.wr_en = 1'b0;
        cmd.sh_en = 1'b0;
        unique case (mode)
            CELL_RAM:   cmd.wr_en = step_en;
            CELL_SHIFT: cmd.sh_en = step_en;
            default:    ;
        endcase
    end
endmodule

// File: rtl/lut_table_store.sv
module lut_table_store
    import lut_cell_pkg::*;
#(
    parameter int                 ADDR_W    = 6,
    parameter int                 SHIFT_LEN = 32,
    parameter logic [(1<<ADDR_W)-1:0] INIT_BITS = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  store_cmd_t                cmd,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      din,
    output logic [(1<<ADDR_W)-1:0]    bits
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] nxt;

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        if (i < SHIFT_LEN) begin : g_shift_stage
            always_comb begin
                nxt[i] = bits[i];
                if (cmd.wr_en && addr == ADDR_W'(i)) nxt[i] = din;
                if (cmd.sh_en) begin
                    if (i == 0) nxt[i] = din;
                    else        nxt[i] = bits[(i == 0) ? 0 : i-1];
                end
            end
        end else begin : g_plain
            always_comb begin
                nxt[i] = bits[i];
                if (cmd.wr_en && addr == ADDR_W'(i)) nxt[i] = din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bits <= INIT_BITS;
        else     bits <= nxt;
    end

    // R4
    ram_write_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.wr_en |=> bits[$past(addr)] == $past(din));

    // R6
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.sh_en |=> bits[SHIFT_LEN-1:0] == {$past(bits[SHIFT_LEN-2:0]), $past(din)});

    // R6
    shift_upper_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.sh_en |=> $stable(bits[DEPTH-1:SHIFT_LEN]));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd.wr_en && !cmd.sh_en) |=> $stable(bits));

endmodule

// File: rtl/lut_read_select.sv
module lut_read_select
    import lut_cell_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SHIFT_LEN = 32
) (
    input  logic [(1<<ADDR_W)-1:0] bits,
    input  logic [ADDR_W-1:0]      addr,
    input  cell_mode_e             mode,
    output logic                   dout,
    output logic                   half,
    output logic                   cascade
);
    localparam int TAP_W = $clog2(SHIFT_LEN);
    localparam int HALF  = 1 << (ADDR_W-1);

    logic [TAP_W-1:0]  tap;
    logic [ADDR_W-2:0] half_idx;
    logic [HALF-1:0]   low_bits;

    assign tap      = addr[TAP_W-1:0];
    assign half_idx = addr[ADDR_W-2:0];
    assign low_bits = bits[HALF-1:0];

    always_comb begin
        half    = low_bits[half_idx];
        dout    = bits[addr];
        cascade = 1'b0;
        if (mode == CELL_SHIFT) begin
            dout    = bits[SHIFT_LEN-1:0][tap];
            cascade = bits[SHIFT_LEN-1];
        end
    end
endmodule

// File: rtl/lut_multimode_cell.sv
module lut_multimode_cell
    import lut_cell_pkg::*;
#(
    parameter int                 ADDR_W    = 6,
    parameter int                 SHIFT_LEN = 32,
    parameter logic [(1<<ADDR_W)-1:0] INIT_BITS = 64'hA5C3_0F96_3C5A_F00D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_mode,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              data_in,
    input  logic              step_en,
    output logic              data_out,
    output logic              half_out,
    output logic              chain_out
);
    localparam int DEPTH = 1 << ADDR_W;

    cell_mode_e       mode;
    store_cmd_t       cmd;
    logic [DEPTH-1:0] table_bits;

    lut_cmd_decode i_decode (
        .op_mode (op_mode),
        .step_en (step_en),
        .mode    (mode),
        .cmd     (cmd)
    );

    lut_table_store #(
        .ADDR_W    (ADDR_W),
        .SHIFT_LEN (SHIFT_LEN),
        .INIT_BITS (INIT_BITS)
    ) i_store (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .addr (sel_addr),
        .din  (data_in),
        .bits (table_bits)
    );

    lut_read_select #(
        .ADDR_W    (ADDR_W),
        .SHIFT_LEN (SHIFT_LEN)
    ) i_read (
        .bits    (table_bits),
        .addr    (sel_addr),
        .mode    (mode),
        .dout    (data_out),
        .half    (half_out),
        .cascade (chain_out)
    );

    // R3 / R12
    logic_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'b00 || op_mode == 2'b11) |=> $stable(table_bits));

    // R10
    half_match_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'b10) |-> half_out == data_out);

    // R9
    chain_tap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'b10 && sel_addr[4:0] == 5'd31) |-> chain_out == data_out);

    // R9
    chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode != 2'b10) |-> !chain_out);

endmodule

// File: tb/test_lut_multimode_cell.sv
`timescale 1ns/1ps
module test_lut_multimode_cell;

    localparam logic [63:0] INIT = 64'hA5C3_0F96_3C5A_F00D;
    localparam logic [1:0] M_LOGIC = 2'b00, M_RAM = 2'b01, M_SHIFT = 2'b10, M_RSVD = 2'b11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_mode = M_LOGIC;
    logic [5:0] sel_addr = '0;
    logic       data_in = 1'b0;
    logic       step_en = 1'b0;
    logic       data_out, half_out, chain_out;

    always #2.5 clk = ~clk;

    lut_multimode_cell i_lut_multimode_cell (
        .clk(clk), .rst(rst), .op_mode(op_mode), .sel_addr(sel_addr),
        .data_in(data_in), .step_en(step_en),
        .data_out(data_out), .half_out(half_out), .chain_out(chain_out)
    );

    typedef struct {
        logic  d;
        logic  h;
        logic  c;
        string tag;
    } exp_t;

    exp_t  sb[$];
    event  sample_ev;
    logic [63:0] model;
    int    n_checks = 0;
    int    n_fail   = 0;
    logic  last_dout;
    bit    finished = 0;

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares with the live outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check_bit(e.tag, "data_out", data_out, e.d);
                check_bit("R10", "half_out", half_out, e.h);
                check_bit("R9", "chain_out", chain_out, e.c);
            end
        end
    end

    // Driver: apply one cycle of stimulus, push expectation, advance model.
    task automatic step(input logic [1:0] m, input logic [5:0] a, input logic d,
                        input logic w, input string tag);
        exp_t e;
        @(negedge clk);
        op_mode = m; sel_addr = a; data_in = d; step_en = w;
        #1;
        e.d   = (m == M_SHIFT) ? model[{1'b0, a[4:0]}] : model[a];
        e.h   = model[{1'b0, a[4:0]}];
        e.c   = (m == M_SHIFT) ? model[31] : 1'b0;
        e.tag = tag;
        sb.push_back(e);
        -> sample_ev;
        last_dout = data_out;
        @(posedge clk);
        if (m == M_RAM && w)        model[a] = d;
        else if (m == M_SHIFT && w) model[31:0] = {model[30:0], d};
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model = INIT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R2: reset contents read through logic mode
        for (int i = 0; i < 64; i++) step(M_LOGIC, 6'(i), 1'b0, 1'b0, "R1");

        // R3: enables ignored in logic mode
        for (int i = 0; i < 16; i++) step(M_LOGIC, 6'(i*4), ~INIT[i*4], 1'b1, "R3");
        for (int i = 0; i < 64; i++) step(M_LOGIC, 6'(i), 1'b0, 1'b0, "R3");

        // R12: reserved encoding behaves as logic mode
        for (int i = 0; i < 16; i++) step(M_RSVD, 6'(63-i), 1'b1, 1'b1, "R12");
        for (int i = 0; i < 64; i++) step(M_RSVD, 6'(i), 1'b0, 1'b0, "R12");

        // R4 / R5: memory writes, immediate read-after-write
        for (int i = 0; i < 64; i++) begin
            logic bv;
            bv = ((i * 7) % 3) == 1;
            step(M_RAM, 6'(i), bv, 1'b1, "R4");
            step(M_RAM, 6'(i), 1'b0, 1'b0, "R5");
        end
        for (int i = 63; i >= 0; i--) step(M_RAM, 6'(i), 1'b0, 1'b0, "R5");

        // R11: contents survive mode changes
        for (int i = 0; i < 64; i++) step(M_LOGIC, 6'(i), 1'b0, 1'b0, "R11");
        for (int i = 0; i < 8; i++)  step(M_SHIFT, 6'(i), 1'b0, 1'b0, "R11");
        for (int i = 0; i < 64; i++) step(M_RAM, 6'(i), 1'b0, 1'b0, "R11");

        // R6: shift a pattern, upper half kept
        for (int i = 0; i < 40; i++) step(M_SHIFT, 6'(i % 32), 1'((i % 5) == 0), 1'b1, "R6");
        for (int i = 32; i < 64; i++) step(M_LOGIC, 6'(i), 1'b0, 1'b0, "R6");

        // R8: shift mode with enable low holds
        for (int i = 0; i < 32; i++) step(M_SHIFT, 6'(i), 1'b1, 1'b0, "R8");

        // R7: delay of tap+1 edges for every tap, addr[5] toggled
        for (int tap = 0; tap < 32; tap++) begin
            int seen;
            logic [5:0] a;
            a = {1'(tap % 2), 5'(tap)};
            for (int k = 0; k < 32; k++) step(M_SHIFT, a, 1'b0, 1'b1, "R7");
            step(M_SHIFT, a, 1'b1, 1'b1, "R7");
            seen = -1;
            for (int k = 1; k <= 33; k++) begin
                step(M_SHIFT, a, 1'b0, 1'b1, "R7");
                if (last_dout === 1'b1 && seen < 0) seen = k;
            end
            check_int("R7", "tap delay", seen, tap + 1);
        end

        // R9: cascade in shift mode and cleared elsewhere
        for (int i = 0; i < 34; i++) step(M_SHIFT, 6'd31, 1'b1, 1'b1, "R9");
        step(M_RAM, 6'd31, 1'b0, 1'b0, "R9");
        step(M_LOGIC, 6'd31, 1'b0, 1'b0, "R9");

        // R1: reset reloads configuration
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model = INIT;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 64; i++) step(M_LOGIC, 6'(i), 1'b0, 1'b0, "R1");

        @(negedge clk);
        #1;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule